// File: doc/BRIEF.md
# Load/Store Address Translator with Fault Status

This block sits between the load/store unit and the memory system. For each data access it takes the virtual address, the access size, the direction and several mode controls, plus the result of an external translation-buffer lookup. It returns either a physical address with an uncacheable marker, or exactly one fault code with a six-bit status word.

The checks run in a fixed order: alignment, virtual-address validity, kernel-only direct-mapped window, lookup miss, per-mode permission and fault-on bits, then the physical address range. The result is registered, so it appears one clock after the request. The direct-mapped window covers addresses whose bits 47:41 equal 0x7e. Inside it, the physical address is the virtual address with bit 40 copied into bits 43:40. Physical addresses with bit 43 set are marked uncacheable and have bits 42:35 cleared.

Top module: `data_xlate`

## Requirements
- R1: Results are registered. `vld_o` equals `req_i` of the previous cycle. With `vld_o` low, `fault_o`, `stat_o`, `pa_o` and `uncached_o` are all zero. `pa_o` and `uncached_o` are zero whenever a fault is reported.
- R2: Sizes are encoded as log2 of the bytes (0..3 = 1,2,4,8). If `va_i & (bytes-1)` is nonzero, the fault is ALIGN (code 1) and the status is only the WR bit (bit 0), set for stores.
- R3: The permission checks use `alt_mode_i` when both `priv_i` and `alt_i` are high. Otherwise they use `cur_mode_i`. Mode 0 is kernel. Permission masks are indexed by the mode number.
- R4: If bits 63:47 of the virtual address are neither all zero nor all one, the fault is PAGE (code 2). The status is BADVA (bit 4) plus ACV (bit 1), plus WR for stores.
- R5: A window access (bits 47:41 = 0x7e) with `cur_mode_i` not equal to kernel gives fault ACV (code 3), with status ACV plus WR for stores. This check uses the current mode even when the alternate mode is selected.
- R6: A window access in kernel mode ignores the lookup result. Its physical address is bits 39:0 of the virtual address, with bit 40 replicated into bits 43:40.
- R7: Outside the window, when `hit_i` is low, the fault is PTE_MISS (code 4) if `pte_i` is set and MISS (code 5) otherwise. The status is MISS (bit 5) plus WR for stores.
- R8: For a store with the mode's write-enable bit clear, the fault is ACV. The status is WR and ACV, plus FONW (bit 3) if `fonw_i` is set. If write is enabled but `fonw_i` is set, the fault is PAGE with status WR and FONW.
- R9: For a load with the mode's read-enable bit clear, the fault is ACV. The status is ACV, plus FONR (bit 2) if `fonr_i` is set. If read is enabled but `fonr_i` is set, the fault is PAGE with status FONR only.
- R10: The translated address is `{ppn_i, va_i[12:0]}`. If this has any bit set above bit 43, the fault is MCHECK (code 6) with zero status.
- R11: A fault-free physical address with bit 43 set raises `uncached_o` and is returned with bits 42:35 cleared.
- R12: Exactly one fault is reported, and the earliest in this order wins: alignment, bad address, window, miss, permission or fault-on, machine check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access present this cycle |
| va_i | input | 64 | Virtual address |
| size_i | input | 2 | log2 of access bytes |
| wr_i | input | 1 | Store (1) or load (0) |
| pte_i | input | 1 | Access fetches a page-table entry |
| alt_i | input | 1 | Request alternate mode |
| priv_i | input | 1 | Issued from privileged code |
| cur_mode_i | input | 2 | Current mode, 0 = kernel |
| alt_mode_i | input | 2 | Alternate mode |
| hit_i | input | 1 | Lookup hit |
| ppn_i | input | 32 | Physical page number from lookup |
| rd_en_i | input | 4 | Read enable per mode |
| wr_en_i | input | 4 | Write enable per mode |
| fonr_i | input | 1 | Fault-on-read bit of entry |
| fonw_i | input | 1 | Fault-on-write bit of entry |
| vld_o | output | 1 | Result valid |
| fault_o | output | 3 | 0 none,1 ALIGN,2 PAGE,3 ACV,4 PTE_MISS,5 MISS,6 MCHECK |
| stat_o | output | 6 | bit0 WR,1 ACV,2 FONR,3 FONW,4 BADVA,5 MISS |
| pa_o | output | 44 | Physical address |
| uncached_o | output | 1 | Access is uncacheable |

## Verification
The block holds no state beyond one output register, so a wrong decision appears at the ports in the cycle right after the request and does not linger into the next request. The risky faults are a misplaced priority step, a mode taken from the wrong source, and a status bit merged into the wrong fault. Each of these shows as a wrong fault code or status bit on a specific combination. The sweeps therefore cross direction, both modes, the alternate-mode controls, the permission masks and the fault-on bits, and they overlap fault sources so that the winner is visible.

// File: rtl/data_xlate.sv
module data_xlate #(
  parameter int VA_W  = 64,
  parameter int PPN_W = 32,
  parameter int PG_SH = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        size_i,
  input  logic              wr_i,
  input  logic              pte_i,
  input  logic              alt_i,
  input  logic              priv_i,
  input  logic [1:0]        cur_mode_i,
  input  logic [1:0]        alt_mode_i,
  input  logic              hit_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [3:0]        rd_en_i,
  input  logic [3:0]        wr_en_i,
  input  logic              fonr_i,
  input  logic              fonw_i,
  output logic              vld_o,
  output logic [2:0]        fault_o,
  output logic [5:0]        stat_o,
  output logic [43:0]       pa_o,
  output logic              uncached_o
);
  localparam int PA_W   = 44;
  localparam int FULL_W = PPN_W + PG_SH;

  localparam logic [2:0] F_NONE = 3'd0, F_ALIGN = 3'd1, F_PAGE = 3'd2, F_ACV = 3'd3,
                         F_PTEM = 3'd4, F_MISS = 3'd5, F_MCHK = 3'd6;
  localparam int S_WR = 0, S_ACV = 1, S_FONR = 2, S_FONW = 3, S_BADVA = 4, S_MISS = 5;

  logic [1:0]        eff_mode;
  logic [3:0]        smask;
  logic              misal, va_ok, spage, mchk, uc;
  logic [FULL_W-1:0] tlb_full;
  logic [PA_W-1:0]   raw_pa, fin_pa;
  logic [2:0]        f_d;
  logic [5:0]        s_d;

  assign eff_mode = (priv_i && alt_i) ? alt_mode_i : cur_mode_i;
  assign smask    = (4'd1 << size_i) - 4'd1;
  assign misal    = |(va_i[2:0] & smask[2:0]);
  assign va_ok    = (&va_i[VA_W-1:47]) | ~(|va_i[VA_W-1:47]);
  assign spage    = va_i[47:41] == 7'h7e;
  assign tlb_full = {ppn_i, va_i[PG_SH-1:0]};
  assign mchk     = |tlb_full[FULL_W-1:PA_W];
  assign raw_pa   = spage ? {{(PA_W-40){va_i[40]}}, va_i[39:0]} : tlb_full[PA_W-1:0];
  assign uc       = raw_pa[PA_W-1];
  assign fin_pa   = uc ? {1'b1, 8'b0, raw_pa[34:0]} : raw_pa;

  always_comb begin
    f_d = F_NONE;
    s_d = '0;
    if (misal) begin
      f_d = F_ALIGN; s_d[S_WR] = wr_i;
    end else if (!va_ok) begin
      f_d = F_PAGE; s_d[S_WR] = wr_i; s_d[S_ACV] = 1'b1; s_d[S_BADVA] = 1'b1;
    end else if (spage) begin
      if (cur_mode_i != 2'd0) begin
        f_d = F_ACV; s_d[S_WR] = wr_i; s_d[S_ACV] = 1'b1;
      end
    end else if (!hit_i) begin
      f_d = pte_i ? F_PTEM : F_MISS; s_d[S_WR] = wr_i; s_d[S_MISS] = 1'b1;
    end else if (wr_i && !wr_en_i[eff_mode]) begin
      f_d = F_ACV; s_d[S_WR] = 1'b1; s_d[S_ACV] = 1'b1; s_d[S_FONW] = fonw_i;
    end else if (wr_i && fonw_i) begin
      f_d = F_PAGE; s_d[S_WR] = 1'b1; s_d[S_FONW] = 1'b1;
    end else if (!wr_i && !rd_en_i[eff_mode]) begin
      f_d = F_ACV; s_d[S_ACV] = 1'b1; s_d[S_FONR] = fonr_i;
    end else if (!wr_i && fonr_i) begin
      f_d = F_PAGE; s_d[S_FONR] = 1'b1;
    end else if (mchk) begin
      f_d = F_MCHK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0; fault_o <= F_NONE; stat_o <= '0; pa_o <= '0; uncached_o <= 1'b0;
    end else begin
      vld_o      <= req_i;
      fault_o    <= req_i ? f_d : F_NONE;
      stat_o     <= req_i ? s_d : '0;
      pa_o       <= (req_i && f_d == F_NONE) ? fin_pa : '0;
      uncached_o <= req_i && f_d == F_NONE && uc;
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> vld_o == $past(req_i));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (fault_o == F_NONE && stat_o == '0 && pa_o == '0 && !uncached_o));
  p_fault_no_pa_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o != F_NONE |-> (pa_o == '0 && !uncached_o));
  p_align_only_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == F_ALIGN |-> stat_o[5:1] == '0);
  p_badva_acv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[S_BADVA] |-> (fault_o == F_PAGE && stat_o[S_ACV]));
  p_miss_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o == F_MISS || fault_o == F_PTEM) |-> (stat_o[S_MISS] && $countones(stat_o[4:1]) == 0));
  p_fonw_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[S_FONW] |-> stat_o[S_WR]);
  p_mchk_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == F_MCHK |-> stat_o == '0);
  p_uc_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uncached_o |-> (pa_o[43] && pa_o[42:35] == '0));
  p_one_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o == F_NONE) |-> stat_o == '0);
endmodule

// File: tb/test_data_xlate.sv
module test_data_xlate;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, wr = 0, pte = 0, alt = 0, priv = 0, hit = 0, fonr = 0, fonw = 0;
  logic [63:0] va = '0;
  logic [1:0]  sz = 0, cm = 0, am = 0;
  logic [31:0] ppn = '0;
  logic [3:0]  re = 0, we = 0;
  logic        vld, uc;
  logic [2:0]  flt;
  logic [5:0]  st;
  logic [43:0] pa;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  data_xlate i_data_xlate (
    .clk(clk), .rst_n(rst_n), .req_i(req), .va_i(va), .size_i(sz), .wr_i(wr), .pte_i(pte),
    .alt_i(alt), .priv_i(priv), .cur_mode_i(cm), .alt_mode_i(am), .hit_i(hit), .ppn_i(ppn),
    .rd_en_i(re), .wr_en_i(we), .fonr_i(fonr), .fonw_i(fonw),
    .vld_o(vld), .fault_o(flt), .stat_o(st), .pa_o(pa), .uncached_o(uc));

  function automatic void model(output logic [2:0] f, output logic [5:0] s,
                                output logic [43:0] p, output logic u);
    logic [1:0]  em;
    logic [44:0] full;
    logic [43:0] raw;
    int          bytes;
    em = (priv && alt) ? am : cm;
    bytes = 1 << sz;
    full = {ppn, va[12:0]};
    raw = (va[47:41] == 7'h7e) ? (va[40] ? {4'hf, va[39:0]} : {4'h0, va[39:0]}) : full[43:0];
    f = 0; s = 0; p = 0; u = 0;
    if ((va % bytes) != 0) begin f = 1; s[0] = wr; end
    else if (va[63:47] != 17'h0 && va[63:47] != 17'h1ffff) begin f = 2; s = {4'b0100, 2'b10} | {5'b0, wr}; end
    else if (va[47:41] == 7'h7e && cm != 0) begin f = 3; s = {4'b0, 1'b1, wr}; end
    else if (va[47:41] != 7'h7e && !hit) begin f = pte ? 4 : 5; s = {1'b1, 4'b0, wr}; end
    else if (va[47:41] != 7'h7e && wr && !we[em]) begin f = 3; s = {2'b0, fonw, 1'b0, 2'b11}; end
    else if (va[47:41] != 7'h7e && wr && fonw) begin f = 2; s = 6'b001001; end
    else if (va[47:41] != 7'h7e && !wr && !re[em]) begin f = 3; s = {3'b0, fonr, 2'b10}; end
    else if (va[47:41] != 7'h7e && !wr && fonr) begin f = 2; s = 6'b000100; end
    else if (va[47:41] != 7'h7e && full[44]) begin f = 6; end
    if (f == 0) begin
      u = raw[43];
      p = u ? {1'b1, 8'h00, raw[34:0]} : raw;
    end
  endfunction

  task automatic run(input string tag);
    logic [2:0] ef; logic [5:0] es; logic [43:0] ep; logic eu;
    model(ef, es, ep, eu);
    req = 1;
    @(negedge clk);
    n_chk++;
    if (vld !== 1'b1 || flt !== ef || st !== es || pa !== ep || uc !== eu) begin
      n_bad++;
      $display("FAIL %s va=%h: got vld=%b f=%0d s=%b pa=%h uc=%b, exp vld=1 f=%0d s=%b pa=%h uc=%b",
               tag, va, vld, flt, st, pa, uc, ef, es, ep, eu);
    end
  endtask

  task automatic defaults();
    va = 64'h0000_0000_0040_2000; sz = 0; wr = 0; pte = 0; alt = 0; priv = 0;
    cm = 0; am = 0; hit = 1; ppn = 32'h0000_1234; re = 4'hf; we = 4'hf; fonr = 0; fonw = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1: got hung run, exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    n_chk++;
    if (vld !== 0 || flt !== 0 || st !== 0 || pa !== 0 || uc !== 0) begin
      n_bad++; $display("FAIL R1 reset: got vld=%b f=%0d, exp 0 0", vld, flt);
    end
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (vld !== 0) begin n_bad++; $display("FAIL R1 idle: got vld=%b, exp 0", vld); end

    // R2 alignment sweep
    for (int l = 0; l < 4; l++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++) begin
          defaults(); sz = 2'(l); va[2:0] = 3'(o); wr = w[0]; run("R2");
        end

    // R3 R8 R9: modes, masks, fault-on bits
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 4; a++)
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 16; m++)
            for (int fo = 0; fo < 4; fo++) begin
              defaults(); cm = 2'(c); am = 2'(a); priv = k[0]; alt = k[1];
              re = 4'(m); we = ~4'(m); fonr = fo[0]; fonw = fo[1];
              wr = 0; run("R3 R9");
              wr = 1; run("R3 R8");
            end

    // R4 bad addresses, also with misalignment (R12)
    for (int b = 47; b < 64; b += 4)
      for (int w = 0; w < 2; w++) begin
        defaults(); va[b] = 1; wr = w[0]; run("R4");
        sz = 3; va[1] = 1; run("R12 align over badva");
      end

    // R5 R6 direct-mapped window
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 2; w++)
          for (int k = 0; k < 2; k++) begin
            defaults(); va = 64'hFFFF_FC00_0000_0000 | (64'(b) << 40) | 64'h0000_0012_3456_7890;
            cm = 2'(c); wr = w[0]; priv = 1; alt = 1; am = k ? 2'd0 : 2'd3;
            hit = 0; re = 0; we = 0; fonr = 1; fonw = 1;
            run("R5 R6 R11");
          end

    // R7 misses and R12 miss over permission
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++)
        for (int q = 0; q < 2; q++) begin
          defaults(); hit = 0; pte = p[0]; wr = w[0]; re = 0; we = 0;
          fonr = q[0]; fonw = q[0]; ppn = 32'hFFFF_FFFF; run("R7 R12");
        end

    // R10 R11 machine check and uncacheable
    for (int t = 0; t < 8; t++)
      for (int w = 0; w < 2; w++) begin
        defaults(); wr = w[0];
        ppn = {t[2], t[1], 30'h0AA5_5A5A} | {1'b0, t[0], 30'h0};
        va[12:0] = 13'h1ff8; sz = 3;
        run("R10 R11");
        re = 0; we = 0; run("R12 perm over mcheck");
      end

    // R1 idle gap after traffic
    req = 0;
    @(negedge clk);
    n_chk++;
    if (vld !== 0 || flt !== 0 || pa !== 0) begin
      n_bad++; $display("FAIL R1 gap: got vld=%b f=%0d pa=%h, exp 0 0 0", vld, flt, pa);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule